// File: doc/BRIEF.md
# MIDI UART Host Port

This block is the processor-facing side of a MIDI interface that follows the classic two-register programming model of intelligent MIDI cards, operating only in pass-through UART mode. The host sees a byte-wide data register at offset 0. At offset 1 there is a command register for writes, and the same offset returns a status byte on reads. Two commands are decoded: a reset and an enter-UART command. Each accepted command is answered by an acknowledge byte that the host collects through the receive path.

On its far side the port has a byte-wide valid/ready handshake in each direction toward a serial MIDI shifter. Transmit bytes are held in a single register until the shifter takes them. Received bytes and acknowledges share a small queue. Two interrupt conditions are offered to an interrupt controller, each gated by its own enable bit: transmit register empty and receive data available.

Top module: `midi_uart_port`

## Requirements
- R1: After reset the port is out of UART mode, the receive queue is empty, the transmit register is empty, `tx_valid` is 0, and the status byte reads 0x80.
- R2: The status byte, read at `host_addr`=1, carries an active-low input-ready flag in bit 7 (0 while the receive queue holds a byte) and an active-low output-ready flag in bit 6 (1 while the transmit register is occupied). Bits 5..0 read 0.
- R3: A command write of 0x3F, accepted while bit 6 is low, enters UART mode and queues the acknowledge byte 0xFE. If the queue is completely full, the acknowledge is lost.
- R4: An accepted command write of 0xFF empties the receive queue, leaves UART mode and then queues the acknowledge 0xFE. Data writes that follow it are discarded.
- R5: Any other command value changes neither the mode nor the queue.
- R6: A data read (`host_addr`=0) returns the oldest queued byte and removes it. A data read with the queue empty returns 0xFF and changes nothing.
- R7: In UART mode, a data write while bit 6 is low loads the byte onto `tx_byte` and raises `tx_valid`, which sets bit 6. Both clear in the cycle after `tx_ready` is seen with `tx_valid` high.
- R8: Data or command writes made while bit 6 is high are dropped, and `tx_byte` keeps its value.
- R9: Outside UART mode, data writes are discarded and `tx_valid` stays 0.
- R10: Serial bytes presented with `rx_valid` and `rx_ready` both high are queued in arrival order. `rx_ready` is high only while at least two queue entries are free.
- R11: When a command acknowledge and a serial byte enter the queue in the same cycle, the acknowledge is queued ahead of the byte.
- R12: `irq_tx_empty` equals `irq_en[1]` AND transmit register empty. `irq_rx_avail` equals `irq_en[0]` AND queue non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = data register, 1 = command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational from `host_addr`) |
| tx_byte | output | 8 | Byte offered to the serial shifter |
| tx_valid | output | 1 | Transmit register occupied |
| tx_ready | input | 1 | Shifter takes `tx_byte` |
| rx_byte | input | 8 | Byte from the serial shifter |
| rx_valid | input | 1 | `rx_byte` is valid |
| rx_ready | output | 1 | Port can accept `rx_byte` |
| irq_en | input | 2 | Bit 1 enables transmit-empty, bit 0 enables receive-available |
| irq_tx_empty | output | 1 | Gated transmit-empty condition |
| irq_rx_avail | output | 1 | Gated receive-available condition |

## Verification
A command acknowledge and an incoming serial byte can both be written into the receive queue in the same clock cycle. The bench provokes this by presenting an enter-UART command write and an `rx_valid` byte together. It then reads the data register twice and expects 0xFE first and the serial byte second. A reset command that arrives with a serial byte already queued is also checked: after it, only the acknowledge may remain.

// File: rtl/midi_uart_port.sv
module midi_uart_port #(
  parameter int RX_DEPTH = 4,
  parameter logic [7:0] CMD_RESET = 8'hFF,
  parameter logic [7:0] CMD_UART = 8'h3F,
  parameter logic [7:0] ACK_BYTE = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] tx_byte,
  output logic       tx_valid,
  input  logic       tx_ready,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [1:0] irq_en,
  output logic       irq_tx_empty,
  output logic       irq_rx_avail
);
  localparam int PW = (RX_DEPTH > 2) ? $clog2(RX_DEPTH) : 1;
  localparam int CW = $clog2(RX_DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(RX_DEPTH);
  localparam logic [CW-1:0] READY_MAX = CW'(RX_DEPTH - 2);

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= RX_DEPTH) s = s - RX_DEPTH;
    return PW'(s);
  endfunction

  logic [7:0]    q [RX_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          uart_on, tx_full;
  logic [7:0]    tx_hold;

  wire wr_data = host_sel & host_wr & ~host_addr;
  wire wr_cmd  = host_sel & host_wr & host_addr;
  wire rd_data = host_sel & ~host_wr & ~host_addr;
  wire q_empty = (cnt == '0);
  wire cmd_ok  = wr_cmd & ~tx_full;
  wire is_rst  = cmd_ok & (host_wdata == CMD_RESET);
  wire is_uart = cmd_ok & (host_wdata == CMD_UART);
  wire ack     = is_rst | (is_uart & (cnt != FULL_CNT));
  wire pop     = rd_data & ~q_empty;
  wire rx_take = rx_valid & rx_ready;

  wire [PW-1:0] wbase = is_rst ? '0 : wp;
  wire [CW-1:0] cbase = is_rst ? '0 : cnt;
  wire [PW-1:0] rx_slot = ack ? adv(wbase, 1) : wbase;

  assign rx_ready     = (cnt <= READY_MAX);
  assign tx_byte      = tx_hold;
  assign tx_valid     = tx_full;
  assign irq_tx_empty = irq_en[1] & ~tx_full;
  assign irq_rx_avail = irq_en[0] & ~q_empty;
  assign host_rdata   = host_addr ? {q_empty, tx_full, 6'b0}
                                  : (q_empty ? 8'hFF : q[rp]);

  always_ff @(posedge clk) begin
    if (ack) q[wbase] <= ACK_BYTE;
    if (rx_take) q[rx_slot] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      wp  <= adv(wbase, int'(ack) + int'(rx_take));
      rp  <= is_rst ? '0 : (pop ? adv(rp, 1) : rp);
      cnt <= cbase + CW'(ack) + CW'(rx_take) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uart_on <= 1'b0;
    else if (is_rst) uart_on <= 1'b0;
    else if (is_uart) uart_on <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_hold <= '0;
    end else if (tx_full) begin
      if (tx_ready) tx_full <= 1'b0;
    end else if (wr_data & uart_on) begin
      tx_full <= 1'b1;
      tx_hold <= host_wdata;
    end
  end
endmodule

module midi_uart_port_chk #(
  parameter int RX_DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic          host_wr,
  input logic          host_addr,
  input logic [7:0]    host_wdata,
  input logic [7:0]    host_rdata,
  input logic [7:0]    tx_byte,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [CW-1:0] cnt,
  input logic          uart_on
);
  wire cmd_w  = host_sel & host_wr & host_addr & ~tx_valid;
  wire data_w = host_sel & host_wr & ~host_addr;

  AST_UART_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && host_wdata == 8'h3F |=> uart_on); // R3
  AST_ACK_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && (host_wdata == 8'hFF || (host_wdata == 8'h3F && cnt != CW'(RX_DEPTH))) |=> cnt != '0); // R3
  AST_RESET_LEAVES_UART: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && host_wdata == 8'hFF |=> !uart_on); // R4
  AST_OTHER_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_w && host_wdata != 8'hFF && host_wdata != 8'h3F && !(rx_valid && rx_ready)
    |=> $stable(cnt) && $stable(uart_on)); // R5
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte)); // R8
  AST_LOCKED_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    data_w && !uart_on && !tx_valid |=> !tx_valid); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(RX_DEPTH)); // R10
  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr |-> host_rdata[5:0] == 6'b0); // R2
endmodule

bind midi_uart_port midi_uart_port_chk #(.RX_DEPTH(RX_DEPTH), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .cnt(cnt), .uart_on(uart_on)
);

// File: tb/midi_uart_port_test.sv
module midi_uart_port_test;
  logic clk = 0, rst_n = 0;
  logic host_sel = 0, host_wr = 0, host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata, tx_byte, rx_byte = 0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [1:0] irq_en = 0;
  logic irq_tx_empty, irq_rx_avail;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  midi_uart_port uut (.*);

  // {is_read, addr, data, expected, requirement}
  localparam logic [21:0] VEC [0:14] = '{
    {1'b1, 1'b1, 8'h00, 8'h80, 4'd1},
    {1'b0, 1'b0, 8'h90, 8'h00, 4'd9},
    {1'b1, 1'b1, 8'h00, 8'h80, 4'd9},
    {1'b0, 1'b1, 8'h12, 8'h00, 4'd5},
    {1'b1, 1'b1, 8'h00, 8'h80, 4'd5},
    {1'b0, 1'b1, 8'h3F, 8'h00, 4'd3},
    {1'b1, 1'b1, 8'h00, 8'h00, 4'd2},
    {1'b1, 1'b0, 8'h00, 8'hFE, 4'd3},
    {1'b1, 1'b1, 8'h00, 8'h80, 4'd6},
    {1'b1, 1'b0, 8'h00, 8'hFF, 4'd6},
    {1'b0, 1'b0, 8'h45, 8'h00, 4'd7},
    {1'b1, 1'b1, 8'h00, 8'hC0, 4'd7},
    {1'b0, 1'b0, 8'h99, 8'h00, 4'd8},
    {1'b0, 1'b1, 8'hFF, 8'h00, 4'd8},
    {1'b1, 1'b1, 8'h00, 8'hC0, 4'd8}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_sel = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    for (int i = 0; i < 15; i++) begin
      if (VEC[i][21]) begin
        rd(VEC[i][20], v);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][11:4]);
      end else wr(VEC[i][20], VEC[i][19:12]);
    end
    check("R8 held byte", tx_byte, 8'h45);
    check("R7 tx_valid", {7'b0, tx_valid}, 8'h01);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    rd(1, v); check("R7 released", v, 8'h80);

    // R10: arrival order and backpressure
    push(8'h31); push(8'h32); push(8'h33);
    check("R10 rx_ready full", {7'b0, rx_ready}, 8'h00);
    rd(0, v); check("R10 first", v, 8'h31);
    rd(0, v); check("R10 second", v, 8'h32);
    rd(0, v); check("R10 third", v, 8'h33);
    check("R10 rx_ready free", {7'b0, rx_ready}, 8'h01);

    // R11: ack and serial byte in the same cycle
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = 1; host_wdata = 8'h3F;
    rx_valid = 1; rx_byte = 8'h55;
    @(negedge clk);
    host_sel = 0; host_wr = 0; rx_valid = 0;
    rd(0, v); check("R11 ack first", v, 8'hFE);
    rd(0, v); check("R11 byte second", v, 8'h55);

    // R4: reset command flushes and leaves UART mode
    push(8'h21);
    wr(1, 8'hFF);
    rd(1, v); check("R4 status", v, 8'h00);
    rd(0, v); check("R4 ack only", v, 8'hFE);
    rd(1, v); check("R4 empty", v, 8'h80);
    wr(0, 8'h11);
    check("R4 data discarded", {7'b0, tx_valid}, 8'h00);

    // R12: interrupt gating
    check("R12 gated off", {6'b0, irq_tx_empty, irq_rx_avail}, 8'h00);
    @(negedge clk); irq_en = 2'b11; #1;
    check("R12 tx empty", {6'b0, irq_tx_empty, irq_rx_avail}, 8'h02);
    push(8'h77); #1;
    check("R12 rx avail", {6'b0, irq_tx_empty, irq_rx_avail}, 8'h03);
    rd(0, v); check("R6 pop", v, 8'h77);
    wr(1, 8'h3F); rd(0, v);
    wr(0, 8'h5A); #1;
    check("R12 tx busy", {6'b0, irq_tx_empty, irq_rx_avail}, 8'h00);
    @(negedge clk); irq_en = 2'b01; #1;
    check("R12 rx enable only", {6'b0, irq_tx_empty, irq_rx_avail}, 8'h00);

    // R1: reset while busy
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check("R1 tx cleared", {7'b0, tx_valid}, 8'h00);
    rd(1, v); check("R1 status", v, 8'h80);
    wr(0, 8'h66);
    check("R1 not in UART", {7'b0, tx_valid}, 8'h00);
    finish_run();
  end
endmodule